// File: doc/BRIEF.md
# Serial-Access Fuse Bit Reader

This block is the read path of a one-time-programmable bit store that is read one bit at a time. The fuse contents arrive as a parameter-sized input vector. An internal address counter selects one bit, and an output latch presents that bit on a tri-state serial data pin. Programming the fuses is not part of this block.

External control comes from three slow pins: a mode pin, a restart pulse and an advance pulse. Each pin passes through a synchronizer on a fast system clock. Its falling and rising edges are then turned into single-cycle strobes.
- A restart pulse points the counter at bit 1.
- Each advance pulse moves to the next bit.
- Once the last bit is reached, the counter saturates and raises an end flag.

With the mode pin high, the block freezes: pulses are ignored and the data pin floats. Driving the mode pin low again resumes exactly where the read left off.

Top module: `serial_fuse_reader`

## Requirements
- R1: After power-on reset, the data output is not driven (`data_oe_o` = 0) and `end_o` is 0.
- R2: A restart pulse in read mode selects bit 1 (vector index 0) and clears `end_o`, and the data output is then driven.
- R3: In read mode, each advance pulse moves the selection from bit N to bit N+1, so the data output shows vector index N.
- R4: `end_o` goes to 1 when the advance pulse that selects the last bit (index BITS-1) is accepted. It is 0 at every earlier address.
- R5: Advance pulses while `end_o` is 1 are ignored: the address, the data output and `end_o` stay unchanged.
- R6: The output latch follows the selected fuse bit while the pin of the accepted pulse is low. From that pin's rising edge on, the latch holds the value it had.
- R7: While the effective mode is hold (mode pin = 1), `data_oe_o` is 0.
- R8: Pulses whose falling edge arrives in hold mode change neither the address nor the latched bit. On return to read mode, the same bit is driven again.
- R9: A change on the mode pin takes effect only once both the restart and advance pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| fuse_bits | input | BITS | Fuse contents; bit N is at index N-1 |
| mode_pin | input | 1 | 0 = read, 1 = hold |
| restart_pin | input | 1 | Restart pulse, active low |
| advance_pin | input | 1 | Advance pulse, active low |
| data_o | output | 1 | Serial data, high impedance when not driven |
| data_oe_o | output | 1 | 1 while `data_o` is driven |
| end_o | output | 1 | Last bit has been reached |

## Verification
The assertions assume the following about the pins:
- The pins are slow next to the clock, so every level lasts many cycles after synchronization.
- The mode pin is only ever changed while both pulse pins idle high.
- Restart and advance pulses do not overlap.

The stimulus follows these rules. It changes each pin on the falling clock edge and then waits eight cycles, which is more than the four-register path from pin to output. Pulses are issued one at a time. The only deliberate departure is the R9 test: there the mode pin is raised while restart is low, to show that the mode change is deferred.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   typedef enum logic {
      MODE_READ = 1'b0,
      MODE_HOLD = 1'b1
   } fsr_mode_e;

   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } fsr_edge_t;

endpackage

// File: rtl/fsr_pin_sync.sv
module fsr_pin_sync
   import fsr_pkg::*;
#(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   output fsr_edge_t ev
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RESET_VAL}};
         last_q  <= RESET_VAL;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         last_q  <= chain_q[STAGES-1];
      end
   end

   always_comb begin
      ev.level = chain_q[STAGES-1];
      ev.rise  = chain_q[STAGES-1] & ~last_q;
      ev.fall  = ~chain_q[STAGES-1] & last_q;
   end

endmodule

// File: rtl/fsr_addr_ctr.sv
module fsr_addr_ctr #(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_first,
   input  logic              advance,
   output logic [ADDR_W-1:0] idx,
   output logic              at_end
);

   localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] PRE_LAST = LAST_IDX - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         at_end <= 1'b0;
      end else if (load_first) begin
         idx    <= '0;
         at_end <= 1'b0;
      end else if (advance && !at_end) begin
         idx    <= idx + 1'b1;
         at_end <= (idx == PRE_LAST);
      end
   end

endmodule

// File: rtl/fsr_out_latch.sv
module fsr_out_latch #(
   parameter int BITS   = 64,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BITS-1:0]   fuse_bits,
   input  logic [ADDR_W-1:0] idx,
   input  logic              open_evt,
   input  logic              arm_evt,
   input  logic              close_evt,
   output logic              bit_q,
   output logic              open_q,
   output logic              valid_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         valid_q <= 1'b0;
         bit_q   <= 1'b0;
      end else begin
         if (open_evt)       open_q <= 1'b1;
         else if (close_evt) open_q <= 1'b0;
         if (arm_evt)        valid_q <= 1'b1;
         if (open_q)         bit_q <= fuse_bits[idx];
      end
   end

endmodule

// File: rtl/serial_fuse_reader.sv
module serial_fuse_reader
   import fsr_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int BITS        = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [BITS-1:0] fuse_bits,
   input  logic            mode_pin,
   input  logic            restart_pin,
   input  logic            advance_pin,
   output logic            data_o,
   output logic            data_oe_o,
   output logic            end_o
);

   localparam int NUM_PINS = 3;
   localparam int P_MODE   = 0;
   localparam int P_RST    = 1;
   localparam int P_ADV    = 2;

   if (BITS != (1 << ADDR_W)) begin : g_bad_size
      $error("BITS must equal 2**ADDR_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pins;
   fsr_edge_t           ev [NUM_PINS];

   assign pins = {advance_pin, restart_pin, mode_pin};

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
      fsr_pin_sync #(
         .STAGES   (SYNC_STAGES),
         .RESET_VAL((p == P_MODE) ? 1'b0 : 1'b1)
      ) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pins[p]),
         .ev   (ev[p])
      );
   end

   fsr_mode_e mode_q;
   logic      hold_q;
   logic      rst_fall, step_fall, rst_lvl, step_lvl, any_rise;
   logic      load_first, advance;

   assign rst_fall  = ev[P_RST].fall;
   assign step_fall = ev[P_ADV].fall;
   assign rst_lvl   = ev[P_RST].level;
   assign step_lvl  = ev[P_ADV].level;
   assign any_rise  = ev[P_RST].rise | ev[P_ADV].rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_READ;
      end else if (rst_lvl && step_lvl) begin
         mode_q <= ev[P_MODE].level ? MODE_HOLD : MODE_READ;
      end
   end

   assign hold_q     = (mode_q == MODE_HOLD);
   assign load_first = rst_fall && !hold_q;
   assign advance    = step_fall && !hold_q && !rst_fall;

   logic [ADDR_W-1:0] idx;
   logic              at_end;

   fsr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_first(load_first),
      .advance   (advance),
      .idx       (idx),
      .at_end    (at_end)
   );

   logic bit_q, open_q, valid_q;

   fsr_out_latch #(.BITS(BITS), .ADDR_W(ADDR_W)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .fuse_bits(fuse_bits),
      .idx      (idx),
      .open_evt (load_first || (advance && !at_end)),
      .arm_evt  (load_first),
      .close_evt(any_rise),
      .bit_q    (bit_q),
      .open_q   (open_q),
      .valid_q  (valid_q)
   );

   assign data_oe_o = valid_q && !hold_q;
   assign data_o    = data_oe_o ? bit_q : 1'bz;
   assign end_o     = at_end;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_q,
   input logic              rst_fall,
   input logic              step_fall,
   input logic              rst_lvl,
   input logic              step_lvl,
   input logic              open_q,
   input logic              bit_q,
   input logic [ADDR_W-1:0] idx,
   input logic              end_o,
   input logic              data_oe_o
);

   AST_HOLD_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> !data_oe_o); // R7

   AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_fall && !hold_q) |=> (idx == '0 && !end_o && data_oe_o)); // R2

   AST_STEP_INCR: assert property (@(posedge clk) disable iff (!rst_n)
      (step_fall && !rst_fall && !hold_q && !end_o) |=> (idx == $past(idx) + 1'b1)); // R3

   AST_END_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (end_o && step_fall && !rst_fall) |=> (end_o && $stable(idx))); // R5

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |=> ($stable(idx) && $stable(end_o))); // R8

   AST_MODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q != $past(hold_q)) |-> ($past(rst_lvl) && $past(step_lvl))); // R9

   AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (!open_q && !rst_fall && !step_fall) |=> $stable(bit_q)); // R6

endmodule

bind serial_fuse_reader fsr_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold_q   (hold_q),
   .rst_fall (rst_fall),
   .step_fall(step_fall),
   .rst_lvl  (rst_lvl),
   .step_lvl (step_lvl),
   .open_q   (open_q),
   .bit_q    (bit_q),
   .idx      (idx),
   .end_o    (end_o),
   .data_oe_o(data_oe_o)
);

// File: tb/tb_serial_fuse_reader.sv
module tb_serial_fuse_reader;

   localparam int          BITS = 64;
   localparam logic [63:0] PAT  = 64'hA5C3_0F96_1E7B_D248;

   localparam int OP_RST  = 0;
   localparam int OP_STEP = 1;
   localparam int OP_HON  = 2;
   localparam int OP_HOFF = 3;
   localparam int NVEC    = 10;
   // Expected index after each op; -1 means the pin is not driven.
   localparam int VOP  [NVEC] = '{OP_RST, OP_STEP, OP_STEP, OP_HON, OP_STEP,
                                  OP_RST, OP_HOFF, OP_STEP, OP_RST, OP_STEP};
   localparam int VIDX [NVEC] = '{0, 1, 2, -1, -1, -1, 2, 3, 0, 1};

   logic            clk = 1'b0;
   logic            rst_n;
   logic [BITS-1:0] fuse;
   logic            mode_pin, restart_pin, advance_pin;
   logic            data_o, data_oe_o, end_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   serial_fuse_reader dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .fuse_bits  (fuse),
      .mode_pin   (mode_pin),
      .restart_pin(restart_pin),
      .advance_pin(advance_pin),
      .data_o     (data_o),
      .data_oe_o  (data_oe_o),
      .end_o      (end_o)
   );

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // Checks the driven data bit and the end flag together.
   task automatic chk_out(input string req, input int exp_idx, input logic exp_end);
      logic [1:0] act;
      logic [1:0] exp;
      act = {data_oe_o, (data_oe_o ? data_o : 1'b0)};
      exp = (exp_idx < 0) ? 2'b00 : {1'b1, fuse[exp_idx]};
      chk(act == exp, req, act, exp);
      chk(end_o == exp_end, req, {1'b0, end_o}, {1'b0, exp_end});
   endtask

   task automatic pulse_rst();
      restart_pin = 1'b0; settle();
      restart_pin = 1'b1; settle();
   endtask

   task automatic pulse_step();
      advance_pin = 1'b0; settle();
      advance_pin = 1'b1; settle();
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-to-end: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; fuse = PAT;
      mode_pin = 1'b0; restart_pin = 1'b1; advance_pin = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      settle();
      chk_out("R1 reset state", -1, 1'b0);

      // Vector walk: restart, advance, hold, ignored pulses, resume.
      for (int v = 0; v < NVEC; v++) begin
         case (VOP[v])
            OP_RST:  pulse_rst();
            OP_STEP: pulse_step();
            OP_HON:  begin mode_pin = 1'b1; settle(); end
            default: begin mode_pin = 1'b0; settle(); end
         endcase
         chk_out((VIDX[v] < 0) ? "R7/R8 hold vector" : "R2/R3/R8 read vector", VIDX[v], 1'b0);
      end

      // Full walk to the last bit.
      pulse_rst();
      chk_out("R2 restart", 0, 1'b0);
      for (int i = 1; i < BITS; i++) begin
         pulse_step();
         chk_out((i == BITS-1) ? "R4 end reached" : "R3/R4 advance", i, (i == BITS-1));
      end
      for (int k = 0; k < 3; k++) begin
         pulse_step();
         chk_out("R5 saturated", BITS-1, 1'b1);
      end
      pulse_rst();
      chk_out("R2 restart clears end", 0, 1'b0);

      // R6: transparent while restart low, held after its rise.
      restart_pin = 1'b0; settle();
      chk_out("R6 open", 0, 1'b0);
      fuse[0] = ~fuse[0]; settle();
      chk_out("R6 follows", 0, 1'b0);
      restart_pin = 1'b1; settle();
      fuse[0] = ~fuse[0]; settle();
      chk(data_o == ~fuse[0], "R6 captured", {1'b0, data_o}, {1'b0, ~fuse[0]});
      pulse_rst();
      chk_out("R6 recapture", 0, 1'b0);

      // R9: mode change deferred until both pulse pins are high.
      restart_pin = 1'b0; settle();
      mode_pin = 1'b1; settle();
      chk_out("R9 deferred", 0, 1'b0);
      restart_pin = 1'b1; settle();
      chk_out("R9 applied", -1, 1'b0);
      mode_pin = 1'b0; settle();
      chk_out("R9/R8 resume", 0, 1'b0);

      finish_run();
   end

endmodule